// File: doc/BRIEF.md
# DDR3 Rank Mode-Register Programming Sequencer

This block generates the per-rank command stream that sets up the mode registers of a multi-rank DDR3 memory. Reset and clock-enable bring-up happen before it runs. It also issues the ZQ calibration command at the end of the init sequence. A single start pulse launches a run, and a mode input sampled with that pulse selects one of two flavours. Init programs MR0 with DLL reset and ends every rank with a long ZQ calibration and its settling time. Handoff first closes all banks of a rank and then loads the user MR0 value. Both flavours use one rank loop and one set of states. A skip mask removes ranks from the run, and a mirror mask selects the address-mirrored encodings of the mode-register commands for individual ranks.

Commands leave the block as single-cycle strobes. Each strobe carries a 5-bit code and the target rank. The first command for every rank is a rank-select with on-die termination forced off. All waits are counted by one shared down-counter that is reloaded for every gap. When the last enabled rank is finished, a one-cycle done pulse marks the end of the run.

States: `ST_IDLE` (waiting for start), `ST_SETTLE` (init only, post-CKE wait), `ST_SEL`, `ST_PRE`, `ST_MR2`, `ST_GAP_A`, `ST_MR3`, `ST_GAP_B`, `ST_MR1`, `ST_MR0`, `ST_ZQCL`, `ST_ZQ_WAIT`, `ST_DONE`.

Transitions:
- From `ST_IDLE`, a start pulse goes to `ST_SETTLE` (init), to `ST_SEL` (handoff with an enabled rank) or to `ST_DONE` (handoff with every rank skipped).
- `ST_SETTLE` leaves on counter expiry, to `ST_SEL` or `ST_DONE`.
- `ST_SEL` goes to `ST_PRE` (handoff) or to `ST_MR2` (init). `ST_PRE` goes to `ST_MR2`.
- `ST_MR2` goes to `ST_GAP_A`, which goes to `ST_MR3` on expiry. `ST_MR3` goes to `ST_GAP_B`, which goes to `ST_MR1` on expiry. `ST_MR1` goes to `ST_MR0`.
- `ST_MR0` goes to `ST_ZQCL` (init), or in handoff to `ST_SEL` for the next enabled rank or to `ST_DONE`.
- `ST_ZQCL` goes to `ST_ZQ_WAIT`, which on expiry goes to `ST_SEL` or `ST_DONE`.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `mrs_rank_sequencer`

## Requirements
- R1: Enabled ranks are served in ascending index order. A rank whose skip bit is 1 gets no command at all. Each served rank starts with a rank-select command (code 1) that has `cmd_odt_off_o` high.
- R2: Within a rank, the mode-register writes come in the order MR2 (base code 4), MR3 (5), MR1 (6), MR0. MR0 is strobed in the cycle right after MR1.
- R3: Exactly T_MRD (default 4) cycles without a command lie between MR2 and MR3, and again between MR3 and MR1.
- R4: When mirror bit r is 1, every mode-register code sent to rank r has bit 4 set (base code + 16). Rank-select, precharge-all and ZQCL codes never carry bit 4.
- R5: In handoff mode (`handoff_i`=1 at start), precharge-all (code 2) is strobed in the cycle after rank-select and before MR2. MR0 uses the user code 8. No ZQCL is sent, and the next rank's select follows MR0 in the next cycle.
- R6: In init mode, MR0 uses the DLL-reset code 7. ZQCL (code 3) follows in the next cycle, and then T_ZQINIT (default 512) cycles without a command pass before the next rank or done.
- R7: In init mode, T_CKE_SETTLE (default 250) cycles without a command pass after the start is accepted, before the first command.
- R8: `done_o` is high for exactly one cycle, in the cycle right after the last rank's sequence ends. With every rank skipped, this is the first cycle after start in handoff mode, or the cycle after the settle wait in init mode.
- R9: A start pulse that arrives while a run is in progress is ignored. Mode and masks are captured at the accepted start, and later changes do not alter the run.
- R10: After reset, no command strobe and no done pulse appear until a start is given.
- R11: Each command is a single-cycle strobe on `cmd_valid_o`, and no command coincides with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| handoff_i | input | 1 | 1 = handoff mode, 0 = init mode; sampled with start |
| skip_mask_i | input | NUM_RANKS | Rank r is skipped when bit r is 1 |
| mirror_mask_i | input | NUM_RANKS | Rank r uses mirrored mode-register codes when bit r is 1 |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_code_o | output | 5 | Command code (1 select, 2 precharge-all, 3 ZQCL, 4 MR2, 5 MR3, 6 MR1, 7 MR0 DLL reset, 8 MR0 user; +16 mirrored) |
| cmd_rank_o | output | RANK_W | Target rank of the command |
| cmd_odt_off_o | output | 1 | High with rank-select: ODT disabled for the rank |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench goes after the following corner cases:
- Sparse skip masks, including all ranks skipped in both modes. A design that mishandles the finder would send commands to a skipped rank, reorder ranks, or hang or strobe early when nothing is enabled.
- Mirror masks that differ between neighbouring ranks. Taking the mirror bit from the wrong rank, or applying it to precharge or ZQCL, shows up as a wrong code.
- The exact cycle of every strobe, checked against a timeline derived from the requirements. Any off-by-one in the shared down-counter moves MR3, MR1, the next rank or done.
- A second start with inverted mode and masks in the middle of a run. A design that does not ignore it would restart, change flavour, or give two done pulses.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SEL,
        ST_PRE,
        ST_MR2,
        ST_GAP_A,
        ST_MR3,
        ST_GAP_B,
        ST_MR1,
        ST_MR0,
        ST_ZQCL,
        ST_ZQ_WAIT,
        ST_DONE
    } seq_state_e;

    localparam int CODE_W = 5;

    localparam logic [CODE_W-1:0] CMD_NONE     = 5'd0;
    localparam logic [CODE_W-1:0] CMD_SEL      = 5'd1;
    localparam logic [CODE_W-1:0] CMD_PRE_ALL  = 5'd2;
    localparam logic [CODE_W-1:0] CMD_ZQCL     = 5'd3;
    localparam logic [CODE_W-1:0] CMD_MR2      = 5'd4;
    localparam logic [CODE_W-1:0] CMD_MR3      = 5'd5;
    localparam logic [CODE_W-1:0] CMD_MR1      = 5'd6;
    localparam logic [CODE_W-1:0] CMD_MR0_DLL  = 5'd7;
    localparam logic [CODE_W-1:0] CMD_MR0_USER = 5'd8;
    localparam logic [CODE_W-1:0] CMD_MIRROR   = 5'd16;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/mrs_wait_counter.sv
module mrs_wait_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // last cycle of a wait window: the counter holds 1
    assign expired_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/mrs_rank_finder.sv
module mrs_rank_finder #(
    parameter int NUM_RANKS = 4,
    parameter int RANK_W    = 2,
    parameter int FROM_W    = 3
) (
    input  logic [NUM_RANKS-1:0] skip_i,
    input  logic [FROM_W-1:0]    from_i,
    output logic                 found_o,
    output logic [RANK_W-1:0]    idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // descending scan so the lowest eligible index wins
        for (int i = NUM_RANKS - 1; i >= 0; i--) begin
            if ((FROM_W'(i) >= from_i) && !skip_i[i]) begin
                found_o = 1'b1;
                idx_o   = RANK_W'(i);
            end
        end
    end
endmodule

// File: rtl/mrs_rank_sequencer.sv
module mrs_rank_sequencer
    import mrs_seq_pkg::*;
#(
    parameter int NUM_RANKS    = 4,
    parameter int RANK_W       = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    parameter int T_MRD        = 4,
    parameter int T_ZQINIT     = 512,
    parameter int T_CKE_SETTLE = 250
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 handoff_i,
    input  logic [NUM_RANKS-1:0] skip_mask_i,
    input  logic [NUM_RANKS-1:0] mirror_mask_i,
    output logic                 cmd_valid_o,
    output logic [4:0]           cmd_code_o,
    output logic [RANK_W-1:0]    cmd_rank_o,
    output logic                 cmd_odt_off_o,
    output logic                 done_o
);
    localparam int FROM_W = RANK_W + 1;
    localparam int CNT_W  = $clog2(max3(T_MRD, T_ZQINIT, T_CKE_SETTLE) + 1);

    seq_state_e             state_q, state_d;
    logic [RANK_W-1:0]      rank_q;
    logic                   mode_q;
    logic [NUM_RANKS-1:0]   skip_q, mirror_q;

    logic                   cnt_load;
    logic [CNT_W-1:0]       cnt_val;
    logic                   cnt_expired;

    logic [FROM_W-1:0]      find_from;
    logic [NUM_RANKS-1:0]   find_mask;
    logic                   find_ok;
    logic [RANK_W-1:0]      find_idx;
    logic [4:0]             mir_bit;

    mrs_wait_counter #(.CNT_W(CNT_W)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .expired_o  (cnt_expired)
    );

    // search from rank 0 at the beginning of a run, from the next rank otherwise
    always_comb begin
        if (state_q == ST_IDLE || state_q == ST_SETTLE) begin
            find_from = '0;
        end else begin
            find_from = {1'b0, rank_q} + FROM_W'(1);
        end
        find_mask = (state_q == ST_IDLE) ? skip_mask_i : skip_q;
    end

    mrs_rank_finder #(
        .NUM_RANKS (NUM_RANKS),
        .RANK_W    (RANK_W),
        .FROM_W    (FROM_W)
    ) u_find (
        .skip_i  (find_mask),
        .from_i  (find_from),
        .found_o (find_ok),
        .idx_o   (find_idx)
    );

    // next-state and wait-counter reload
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!handoff_i) begin
                        state_d  = ST_SETTLE;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(T_CKE_SETTLE);
                    end else begin
                        state_d = find_ok ? ST_SEL : ST_DONE;
                    end
                end
            end
            ST_SETTLE:  if (cnt_expired) state_d = find_ok ? ST_SEL : ST_DONE;
            ST_SEL:     state_d = mode_q ? ST_PRE : ST_MR2;
            ST_PRE:     state_d = ST_MR2;
            ST_MR2: begin
                state_d  = ST_GAP_A;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(T_MRD);
            end
            ST_GAP_A:   if (cnt_expired) state_d = ST_MR3;
            ST_MR3: begin
                state_d  = ST_GAP_B;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(T_MRD);
            end
            ST_GAP_B:   if (cnt_expired) state_d = ST_MR1;
            ST_MR1:     state_d = ST_MR0;
            ST_MR0: begin
                if (mode_q) state_d = find_ok ? ST_SEL : ST_DONE;
                else        state_d = ST_ZQCL;
            end
            ST_ZQCL: begin
                state_d  = ST_ZQ_WAIT;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(T_ZQINIT);
            end
            ST_ZQ_WAIT: if (cnt_expired) state_d = find_ok ? ST_SEL : ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and run context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rank_q   <= '0;
            mode_q   <= 1'b0;
            skip_q   <= '0;
            mirror_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                mode_q   <= handoff_i;
                skip_q   <= skip_mask_i;
                mirror_q <= mirror_mask_i;
            end
            if (state_d == ST_SEL && state_q != ST_SEL) begin
                rank_q <= find_idx;
            end
        end
    end

    // command outputs decoded from the current state
    always_comb begin
        mir_bit       = mirror_q[rank_q] ? CMD_MIRROR : CMD_NONE;
        cmd_valid_o   = 1'b1;
        cmd_code_o    = CMD_NONE;
        cmd_rank_o    = rank_q;
        cmd_odt_off_o = 1'b0;
        done_o        = 1'b0;
        unique case (state_q)
            ST_SEL: begin
                cmd_code_o    = CMD_SEL;
                cmd_odt_off_o = 1'b1;
            end
            ST_PRE:  cmd_code_o = CMD_PRE_ALL;
            ST_MR2:  cmd_code_o = CMD_MR2 | mir_bit;
            ST_MR3:  cmd_code_o = CMD_MR3 | mir_bit;
            ST_MR1:  cmd_code_o = CMD_MR1 | mir_bit;
            ST_MR0:  cmd_code_o = (mode_q ? CMD_MR0_USER : CMD_MR0_DLL) | mir_bit;
            ST_ZQCL: cmd_code_o = CMD_ZQCL;
            ST_DONE: begin
                cmd_valid_o = 1'b0;
                done_o      = 1'b1;
            end
            default: cmd_valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/mrs_rank_sequencer_chk.sv
module mrs_rank_sequencer_chk
    import mrs_seq_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    parameter int RANK_W    = 2,
    parameter int T_MRD     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [4:0]           cmd_code,
    input logic [RANK_W-1:0]    cmd_rank,
    input logic                 cmd_odt_off,
    input logic                 done,
    input logic [NUM_RANKS-1:0] skip_q,
    input logic [NUM_RANKS-1:0] mirror_q,
    input logic                 mode_q
);
    logic [4:0] last_base;
    logic [7:0] idle_cnt;
    logic [4:0] base;
    logic       is_mr;

    assign base  = cmd_code & 5'h0F;
    assign is_mr = (base >= CMD_MR2) && (base <= CMD_MR0_USER);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_base <= CMD_NONE;
            idle_cnt  <= '0;
        end else if (cmd_valid) begin
            last_base <= base;
            idle_cnt  <= '0;
        end else if (idle_cnt != 8'hFF) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    p_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !skip_q[cmd_rank]);
    p_sel_odt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_SEL) |-> cmd_odt_off);
    p_mr0_follows_mr1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (base == CMD_MR0_DLL || base == CMD_MR0_USER))
            |-> (last_base == CMD_MR1 && idle_cnt == 8'd0));
    p_mr3_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && base == CMD_MR3) |-> (last_base == CMD_MR2 && idle_cnt == 8'(T_MRD)));
    p_mr1_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && base == CMD_MR1) |-> (last_base == CMD_MR3 && idle_cnt == 8'(T_MRD)));
    p_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_mr) |-> (cmd_code[4] == mirror_q[cmd_rank]));
    p_plain_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !is_mr) |-> !cmd_code[4]);
    p_pre_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_PRE_ALL) |-> mode_q);
    p_zq_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == CMD_ZQCL) |-> !mode_q);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid);
endmodule

bind mrs_rank_sequencer mrs_rank_sequencer_chk #(
    .NUM_RANKS (NUM_RANKS),
    .RANK_W    (RANK_W),
    .T_MRD     (T_MRD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid_o),
    .cmd_code    (cmd_code_o),
    .cmd_rank    (cmd_rank_o),
    .cmd_odt_off (cmd_odt_off_o),
    .done        (done_o),
    .skip_q      (skip_q),
    .mirror_q    (mirror_q),
    .mode_q      (mode_q)
);

// File: tb/tb_mrs_rank_sequencer.sv
`timescale 1ns/1ps
module tb_mrs_rank_sequencer;
    localparam int NR     = 4;
    localparam int RW     = 2;
    localparam int TMRD   = 4;
    localparam int TZQ    = 512;
    localparam int TCKE   = 250;
    localparam int NVEC   = 7;

    // {handoff, skip[3:0], mirror[3:0], expected command count[7:0]}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 4'b0000, 4'b0000, 8'd24},
        {1'b1, 4'b0101, 4'b1010, 8'd12},
        {1'b0, 4'b0000, 4'b1010, 8'd24},
        {1'b0, 4'b1110, 4'b0001, 8'd6},
        {1'b1, 4'b1111, 4'b0000, 8'd0},
        {1'b0, 4'b1111, 4'b1111, 8'd0},
        {1'b1, 4'b0110, 4'b1111, 8'd12}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          handoff_i = 1'b0;
    logic [NR-1:0] skip_mask_i = '0;
    logic [NR-1:0] mirror_mask_i = '0;
    logic          cmd_valid_o;
    logic [4:0]    cmd_code_o;
    logic [RW-1:0] cmd_rank_o;
    logic          cmd_odt_off_o;
    logic          done_o;

    always #2.5 clk = ~clk;

    mrs_rank_sequencer #(
        .NUM_RANKS(NR), .RANK_W(RW), .T_MRD(TMRD), .T_ZQINIT(TZQ), .T_CKE_SETTLE(TCKE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .handoff_i(handoff_i),
        .skip_mask_i(skip_mask_i), .mirror_mask_i(mirror_mask_i),
        .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o), .cmd_rank_o(cmd_rank_o),
        .cmd_odt_off_o(cmd_odt_off_o), .done_o(done_o)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int n_act = 0;
    int done_cnt = 0;
    int done_cyc = 0;
    int ek = 0;
    int act_code [64];
    int act_rank [64];
    int act_cyc  [64];
    int act_odt  [64];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor samples away from the active edge
    always @(negedge clk) begin
        if (cmd_valid_o && n_act < 64) begin
            act_code[n_act] = int'(cmd_code_o);
            act_rank[n_act] = int'(cmd_rank_o);
            act_cyc[n_act]  = cyc;
            act_odt[n_act]  = int'(cmd_odt_off_o);
            n_act = n_act + 1;
        end
        if (done_o) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare one expected command against the captured stream
    task automatic exp_cmd(input int code, input int r, input int t, input string req);
        if (ek < n_act) begin
            chk(act_code[ek] == code, req, act_code[ek], code);
            chk(act_rank[ek] == r, {req, " rank"}, act_rank[ek], r);
            chk(act_cyc[ek] == t, {req, " cycle"}, act_cyc[ek], t);
            if (code == 1) chk(act_odt[ek] == 1, "R1 odt off", act_odt[ek], 1);
        end else begin
            chk(1'b0, {req, " missing"}, n_act, ek + 1);
        end
        ek++;
    endtask

    task automatic run_vec(input bit mode, input logic [3:0] skip, input logic [3:0] mir,
                           input int exp_n, input bit disturb);
        int s, t, mb;
        @(posedge clk);
        n_act = 0;
        done_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; handoff_i = mode; skip_mask_i = skip; mirror_mask_i = mir;
        s = cyc;
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            // R9: second start with flipped mode and masks mid-run
            repeat (4) @(negedge clk);
            start_i = 1'b1; handoff_i = !mode; skip_mask_i = ~skip; mirror_mask_i = ~mir;
            @(negedge clk);
            start_i = 1'b0;
        end
        for (int w = 0; w < 3000 && done_cnt == 0; w++) @(negedge clk);
        repeat (4) @(negedge clk);

        chk(n_act == exp_n, "R1 command count", n_act, exp_n);
        ek = 0;
        t = s + 1 + (mode ? 0 : TCKE);
        for (int r = 0; r < NR; r++) begin
            if (skip[r]) continue;
            mb = mir[r] ? 16 : 0;
            exp_cmd(1, r, t, "R1 select");
            t++;
            if (mode) begin
                exp_cmd(2, r, t, "R5 precharge");
                t++;
            end
            exp_cmd(4 + mb, r, t, "R4 MR2");
            t += TMRD + 1;
            exp_cmd(5 + mb, r, t, "R3 MR3");
            t += TMRD + 1;
            exp_cmd(6 + mb, r, t, "R2 MR1");
            t++;
            exp_cmd((mode ? 8 : 7) + mb, r, t, mode ? "R5 MR0 user" : "R6 MR0 dll");
            t++;
            if (!mode) begin
                exp_cmd(3, r, t, "R6 ZQCL");
                t += TZQ + 1;
            end
        end
        chk(done_cnt == 1, "R8 done count", done_cnt, 1);
        chk(done_cyc == t, mode ? "R8 done cycle" : "R7 done cycle", done_cyc, t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: quiet while idle after reset
        chk(cmd_valid_o == 1'b0, "R10 cmd_valid", int'(cmd_valid_o), 0);
        chk(done_o == 1'b0, "R10 done", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(cmd_valid_o == 1'b0 && done_o == 1'b0, "R10 idle after release",
            int'(cmd_valid_o) + int'(done_o), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_vec(VEC[v][16], VEC[v][15:12], VEC[v][11:8], int'(VEC[v][7:0]), 1'b0);
        end

        // R9 directed: restart attempts while busy, in both modes
        run_vec(1'b1, 4'b0000, 4'b0011, 24, 1'b1);
        run_vec(1'b0, 4'b1010, 4'b0100, 12, 1'b1);

        // R11: single-cycle strobes, nothing left pending
        repeat (10) @(negedge clk);
        chk(cmd_valid_o == 1'b0, "R11 idle strobe", int'(cmd_valid_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #750000;
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule